// File: doc/BRIEF.md
# Zero-Suppressing Seven-Segment Decimal Display Decoder

This block turns a fixed-length decimal number, one BCD digit per position, into the segment patterns a row of seven-segment digits needs. It hides digits that carry no value: zeros ahead of the first significant integer digit, and zeros after the last significant fractional digit. Zeros that sit between significant digits stay lit. Suppression is passed from stage to stage. On the integer side it moves from the most significant digit down toward the radix point. On the fractional side it moves from the least significant digit up toward the radix point.

Every stage also has its own active-low blank input, which turns off all segments of that digit. Two enable inputs start the two suppression chains, so either chain can be switched off. A parameter chooses the output polarity: lit segments are driven high for common-cathode displays and low for common-anode displays. The block has no registers. Every output follows the inputs within the same cycle.

Digit index 0 is the least significant fractional digit. Indices 0 to N_FRAC-1 form the fraction. Indices N_FRAC to N_FRAC+N_INT-1 form the integer part, and index N_FRAC is the units digit.

Top module: `zbseg_decoder`

## Requirements
- R1: Each digit maps to 7 segment bits, with bit 0 = a, bit 1 = b, up to bit 6 = g. With common-cathode polarity the lit patterns (g..a) are: 0=0x3F, 1=0x06, 2=0x5B, 3=0x4F, 4=0x66, 5=0x6D, 6=0x7D, 7=0x07, 8=0x7F, 9=0x6F.
- R2: When a digit's active-low blank input is 0, all seven of its segments are dark.
- R3: A BCD code from 10 to 15 shows no lit segment.
- R4: When zb_int_i is 1, an integer digit other than the units digit goes dark if its value is 0 and every more significant digit is also 0.
- R5: A zero that has a nonzero digit on both sides of it, within its own integer or fractional part, stays lit. For example, 0400.70 shows as 400.7 and 0040.07 shows as 40.07.
- R6: The units digit is never suppressed by the zero rule, so an all-zero integer part shows one 0.
- R7: When zb_frac_i is 1, a fractional digit goes dark if its value is 0 and every less significant fractional digit is also 0. For example, 0036.70 shows as 36.7.
- R8: When zb_int_i is 0, no integer digit is suppressed. When zb_frac_i is 0, no fractional digit is suppressed.
- R9: With COMMON_ANODE=1, every output bit is the inverse of the common-cathode value.
- R10: Forcing a digit dark with its blank input does not change how suppression passes to the next digit. The chain depends only on digit values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bcd_i | input | 4*(N_INT+N_FRAC) | BCD digits; digit k is in bits [4k+3:4k] |
| blank_n_i | input | N_INT+N_FRAC | Active-low forced blank, one bit per digit |
| zb_int_i | input | 1 | Enables suppression of leading integer zeros |
| zb_frac_i | input | 1 | Enables suppression of trailing fractional zeros |
| seg_o | output | 7*(N_INT+N_FRAC) | Segment drives; digit k is in bits [7k+6:7k] |

## Verification
Every result is due in the same cycle as the stimulus that causes it, because no register lies between inputs and outputs. The bench changes inputs just after a rising edge and compares at the following falling edge, so the outputs have settled before they are read. Two instances, one per polarity, are checked against a behavioural model. The model scans digit values from each end of the number to decide which digits are dark.

// File: rtl/zbseg_pkg.sv
package zbseg_pkg;
  typedef logic [6:0] seg7_t;

  // lit pattern, bit0 = a ... bit6 = g, common-cathode sense
  function automatic seg7_t bcd_to_lit(input logic [3:0] v);
    seg7_t r;
    case (v)
      4'd0: r = 7'h3F;
      4'd1: r = 7'h06;
      4'd2: r = 7'h5B;
      4'd3: r = 7'h4F;
      4'd4: r = 7'h66;
      4'd5: r = 7'h6D;
      4'd6: r = 7'h7D;
      4'd7: r = 7'h07;
      4'd8: r = 7'h7F;
      4'd9: r = 7'h6F;
      default: r = 7'h00;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/zbseg_stage.sv
module zbseg_stage
  import zbseg_pkg::*;
#(
  parameter bit KEEP = 1'b0
) (
  input  logic [3:0] bcd_i,
  input  logic       blank_n_i,
  input  logic       zb_in_i,
  output logic       zb_out_o,
  output logic       zb_dark_o,
  output seg7_t      lit_o
);
  logic is_zero;

  always_comb begin
    is_zero   = (bcd_i == 4'd0);
    zb_out_o  = zb_in_i & is_zero;
    zb_dark_o = zb_out_o & ~KEEP;
    lit_o     = (blank_n_i && !zb_dark_o) ? bcd_to_lit(bcd_i) : 7'h00;
  end
endmodule

// File: rtl/zbseg_drive.sv
module zbseg_drive
  import zbseg_pkg::*;
#(
  parameter bit ANODE = 1'b0
) (
  input  seg7_t lit_i,
  output seg7_t pin_o
);
  generate
    if (ANODE) begin : g_anode
      assign pin_o = ~lit_i;
    end else begin : g_cathode
      assign pin_o = lit_i;
    end
  endgenerate
endmodule

// File: rtl/zbseg_decoder.sv
module zbseg_decoder
  import zbseg_pkg::*;
#(
  parameter int N_INT        = 4,
  parameter int N_FRAC       = 2,
  parameter bit COMMON_ANODE = 1'b0
) (
  input  logic [4*(N_INT+N_FRAC)-1:0] bcd_i,
  input  logic [N_INT+N_FRAC-1:0]     blank_n_i,
  input  logic                        zb_int_i,
  input  logic                        zb_frac_i,
  output logic [7*(N_INT+N_FRAC)-1:0] seg_o
);
  localparam int NDIG  = N_INT + N_FRAC;
  localparam int UNITS = N_FRAC;

  logic  zbi  [NDIG];
  logic  zbo  [NDIG];
  logic  dark [NDIG];
  seg7_t lit  [NDIG];
  seg7_t pin  [NDIG];

  genvar k;
  generate
    for (k = 0; k < NDIG; k++) begin : g_dig
      // chain wiring: integer side flows downward, fraction side upward
      if (k == NDIG - 1 && k >= UNITS) begin : g_msd
        assign zbi[k] = zb_int_i;
      end else if (k >= UNITS) begin : g_int
        assign zbi[k] = zbo[k+1];
      end else if (k == 0) begin : g_lsd
        assign zbi[k] = zb_frac_i;
      end else begin : g_frac
        assign zbi[k] = zbo[k-1];
      end

      zbseg_stage #(.KEEP(k == UNITS)) stage_i (
        .bcd_i    (bcd_i[4*k +: 4]),
        .blank_n_i(blank_n_i[k]),
        .zb_in_i  (zbi[k]),
        .zb_out_o (zbo[k]),
        .zb_dark_o(dark[k]),
        .lit_o    (lit[k])
      );

      zbseg_drive #(.ANODE(COMMON_ANODE)) drive_i (
        .lit_i(lit[k]),
        .pin_o(pin[k])
      );

      assign seg_o[7*k +: 7] = pin[k];

      always_comb begin
        AST_FORCED_DARK: assert (blank_n_i[k] || lit[k] == 7'h00); // R2
        AST_BAD_CODE_DARK: assert (bcd_i[4*k+3 -: 4] <= 4'd9 || lit[k] == 7'h00); // R3
        AST_DARK_IS_ZERO: assert (!dark[k] || bcd_i[4*k +: 4] == 4'd0); // R10
      end

      if (k > UNITS && k < NDIG - 1) begin : g_a_int
        always_comb begin
          AST_LEAD_PREFIX: assert (!dark[k] || dark[k+1]); // R4
        end
      end
      if (k > UNITS && k == NDIG - 1) begin : g_a_msd
        always_comb begin
          AST_LEAD_START: assert (!dark[k] || zb_int_i); // R8
        end
      end
      if (k == UNITS) begin : g_a_units
        always_comb begin
          AST_UNITS_SHOWN: assert (!(zbo[k] && blank_n_i[k]) || lit[k] == 7'h3F); // R6
        end
      end
      if (k < UNITS && k > 0) begin : g_a_frac
        always_comb begin
          AST_TRAIL_SUFFIX: assert (!dark[k] || dark[k-1]); // R7
        end
      end
      if (k == 0 && UNITS > 0) begin : g_a_lsd
        always_comb begin
          AST_TRAIL_START: assert (!dark[k] || zb_frac_i); // R8
        end
      end
      if (k == UNITS - 1) begin : g_a_radix
        always_comb begin
          AST_FRAC_ALL_ZERO: assert (!zbo[k] || bcd_i[4*UNITS-1:0] == '0); // R7
        end
      end
    end
  endgenerate
endmodule

// File: tb/zbseg_decoder_tb_top.sv
module zbseg_decoder_tb_top;
  localparam int NI = 4;
  localparam int NF = 2;
  localparam int ND = NI + NF;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [4*ND-1:0] bcd;
  logic [ND-1:0]   bn;
  logic            zi, zf;
  logic [7*ND-1:0] seg_cc, seg_ca;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  zbseg_decoder #(.N_INT(NI), .N_FRAC(NF), .COMMON_ANODE(1'b0)) dut_i (
    .bcd_i(bcd), .blank_n_i(bn), .zb_int_i(zi), .zb_frac_i(zf), .seg_o(seg_cc));
  zbseg_decoder #(.N_INT(NI), .N_FRAC(NF), .COMMON_ANODE(1'b1)) dut_ca_i (
    .bcd_i(bcd), .blank_n_i(bn), .zb_int_i(zi), .zb_frac_i(zf), .seg_o(seg_ca));

  int dig [ND];

  function automatic bit seg_on(int d, int s);
    case (s)
      0: return d inside {0, 2, 3, 5, 6, 7, 8, 9};
      1: return d inside {0, 1, 2, 3, 4, 7, 8, 9};
      2: return d inside {0, 1, 3, 4, 5, 6, 7, 8, 9};
      3: return d inside {0, 2, 3, 5, 6, 8, 9};
      4: return d inside {0, 2, 6, 8};
      5: return d inside {0, 4, 5, 6, 8, 9};
      default: return d inside {2, 3, 4, 5, 6, 8, 9};
    endcase
  endfunction

  function automatic logic [7*ND-1:0] model();
    logic [7*ND-1:0] r = '0;
    bit hide [ND];
    bit run;
    for (int k = 0; k < ND; k++) hide[k] = 0;
    run = zi;
    for (int k = ND - 1; k > NF; k--) begin
      run = run && (dig[k] == 0);
      if (run) hide[k] = 1;
    end
    run = zf;
    for (int k = 0; k < NF; k++) begin
      run = run && (dig[k] == 0);
      if (run) hide[k] = 1;
    end
    for (int k = 0; k < ND; k++)
      for (int s = 0; s < 7; s++)
        r[7*k+s] = bn[k] && !hide[k] && seg_on(dig[k], s);
    return r;
  endfunction

  task automatic set_val(int v);
    int t = v;
    for (int k = 0; k < ND; k++) begin
      dig[k] = t % 10;
      t = t / 10;
    end
  endtask

  task automatic apply_check(string tag);
    logic [7*ND-1:0] exp;
    @(posedge clk);
    #1;
    for (int k = 0; k < ND; k++) bcd[4*k +: 4] = 4'(dig[k]);
    @(negedge clk);
    exp = model();
    total++;
    if (seg_cc !== exp) begin
      bad++;
      $display("FAIL %s cathode got=%h exp=%h", tag, seg_cc, exp);
    end
    total++;
    if (seg_ca !== ~exp) begin
      bad++;
      $display("FAIL %s R9 anode got=%h exp=%h", tag, seg_ca, ~exp);
    end
  endtask

  initial begin
    #2000000;
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog expired got=hung exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int seed;
    bcd = '0; bn = '1; zi = 1'b1; zf = 1'b1;
    set_val(0);
    apply_check("R6 all-zero shows single 0");
    set_val(40070);
    apply_check("R4 R5 R7 0400.70");
    set_val(3670);
    apply_check("R7 0036.70");
    set_val(4007);
    apply_check("R5 0040.07 inner fractional zero");
    set_val(123456);
    apply_check("R1 full number");
    set_val(100);
    apply_check("R7 0001.00");
    for (int d = 1; d <= 9; d++) begin
      set_val(d * 111111);
      apply_check("R1 digit sweep");
    end
    zi = 1'b0;
    set_val(3670);
    apply_check("R8 integer chain off");
    zi = 1'b1; zf = 1'b0;
    apply_check("R8 fraction chain off");
    zf = 1'b1;
    bn = 6'b111011;
    set_val(40070);
    apply_check("R2 forced blank on units");
    bn = 6'b011111;
    set_val(3670);
    apply_check("R10 forced blank on leading zero keeps chain");
    bn = 6'b111110;
    set_val(3670);
    apply_check("R10 forced blank on fraction LSD keeps chain");
    bn = '1;
    dig[5] = 0; dig[4] = 0; dig[3] = 12; dig[2] = 5; dig[1] = 0; dig[0] = 0;
    apply_check("R3 invalid code stops chain and is dark");
    dig[5] = 15; dig[4] = 10; dig[3] = 9; dig[2] = 0; dig[1] = 11; dig[0] = 0;
    apply_check("R3 several invalid codes");
    seed = 7;
    for (int i = 0; i < 300; i++) begin
      for (int k = 0; k < ND; k++) begin
        seed = (seed * 1103515245 + 12345) & 32'h7fffffff;
        dig[k] = ((seed >> 16) % 3 == 0) ? 0 : (seed >> 8) % 16;
      end
      seed = (seed * 1103515245 + 12345) & 32'h7fffffff;
      bn = ((seed >> 10) % 4 == 0) ? 6'((seed >> 4)) : '1;
      zi = ((seed >> 20) % 5) != 0;
      zf = ((seed >> 22) % 5) != 0;
      apply_check("R1 R4 R7 random");
    end
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule